// File: doc/BRIEF.md
# System Control and Status Port

This block is a byte-wide I/O register for a PC-compatible chipset. It holds the control bits for the speaker timer channel. One bit enables that channel's clock and another lets the timer's output reach the speaker line. The block also captures two error conditions: memory parity faults seen on local reads, and channel-check faults raised on the expansion bus. It raises a non-maskable interrupt request while either captured fault is present and the external NMI mask is clear.

On a read, the byte also reports the live timer-2 output and a flip-flop that toggles once per refresh cycle. Software clears a captured fault by writing 1 to the matching disable bit, and re-arms capture by writing 0 to it. The register answers at every odd address in a small window.

Top module: `sys_ctl_port`

## Requirements
- R1: The port is selected only when the address is odd and lies between BASE_LO (0x61) and BASE_HI (0x6F) inclusive. Even addresses and addresses outside the window neither write the register nor drive read data. Read data is 0 whenever the port is not both selected and read.
- R2: After reset, control bits 3..0 are 0, the refresh toggle is 0, both fault flags are clear, and t2_gate, spkr_out and nmi_req are low.
- R3: Bit 0 is read/write and drives t2_gate. A written value appears on t2_gate after the clock edge that accepts the write.
- R4: Bit 1 is read/write. spkr_out equals t2_out while bit 1 is 1, and spkr_out is held low while bit 1 is 0.
- R5: Read bit 5 returns the current level of t2_out.
- R6: Read bit 4 inverts once for each clock cycle in which refresh_pulse is high.
- R7: A rising edge on par_err_in sets the parity flag, but only while capture is enabled. Capture is enabled when bit 2 is 0 and par_cfg_dis is 0. Read bit 7 returns the flag. An input that is held high does not set the flag a second time.
- R8: While bit 2 is 1 or par_cfg_dis is 1, the parity flag is cleared one cycle later and stays clear.
- R9: A rising edge on chk_err_in sets the channel-check flag while bit 3 is 0. Read bit 6 returns the flag ORed with the raw chk_err_in. Writing 1 to bit 3 clears the flag one cycle later and keeps it clear. Bit 6 still follows the raw input during that time, but it raises no interrupt.
- R10: nmi_req is high exactly when at least one fault flag is set and nmi_mask is 0.
- R11: Writes to bits 7..4 have no effect. A selected read returns all eight bits in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| par_err_in | input | 1 | Raw parity fault from the memory path |
| chk_err_in | input | 1 | Raw channel-check fault from the expansion bus |
| refresh_pulse | input | 1 | One cycle high per refresh cycle |
| t2_out | input | 1 | Timer channel 2 output |
| nmi_mask | input | 1 | External NMI mask, 1 blocks the request |
| par_cfg_dis | input | 1 | Configuration-level parity disable |
| t2_gate | output | 1 | Clock enable for timer channel 2 |
| spkr_out | output | 1 | Gated speaker signal |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bound assertions check several relations on every cycle:
- the interrupt request follows the flags and the mask;
- the speaker line never rises without the timer output;
- an even-address read returns zero;
- a held disable keeps its flag clear;
- the refresh toggle inverts on every pulse;
- an accepted write lands on the gate output.

Only the directed scenarios show the rest: rising-edge-only capture, re-arming after a clear, the raw channel-check level reading through while its flag is disabled, the decode edges at the ends of the window, and reads that ignore writes to the status bits.

// File: rtl/scp_pkg.sv
package scp_pkg;
   localparam int unsigned BIT_T2GATE = 0;
   localparam int unsigned BIT_SPKR   = 1;
   localparam int unsigned BIT_PARDIS = 2;
   localparam int unsigned BIT_CHKDIS = 3;
   localparam int unsigned BIT_REFTOG = 4;
   localparam int unsigned BIT_T2OUT  = 5;
   localparam int unsigned BIT_CHK    = 6;
   localparam int unsigned BIT_PAR    = 7;

   typedef struct packed {
      logic chk_dis;
      logic par_dis;
      logic spkr_en;
      logic t2_gate;
   } ctrl_t;
endpackage

// File: rtl/scp_addr_dec.sv
module scp_addr_dec #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BASE_LO = 'h61,
   parameter int unsigned BASE_HI = 'h6F
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_LO);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_HI);

   initial begin
      assert (BASE_LO <= BASE_HI) else $error("scp_addr_dec: empty window");
      assert (ADDR_W >= 8) else $error("scp_addr_dec: ADDR_W too small");
   end

   always_comb begin
      hit = addr[0] && (addr >= LO) && (addr <= HI);
   end
endmodule

// File: rtl/scp_err_latch.sv
module scp_err_latch #(
   parameter bit EDGE_SENSE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err_in,
   input  logic enable,
   output logic flag
);
   logic set_now;

   generate
      if (EDGE_SENSE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= err_in;
         end
         assign set_now = err_in & ~prev_q;
      end else begin : g_level
         assign set_now = err_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (!enable) flag <= 1'b0;
      else if (set_now) flag <= 1'b1;
   end
endmodule

// File: rtl/scp_toggle.sv
module scp_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= 1'b0;
      else if (pulse) q <= ~q;
   end
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
   import scp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BASE_LO    = 'h61,
   parameter int unsigned BASE_HI    = 'h6F,
   parameter bit          EDGE_SENSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              par_err_in,
   input  logic              chk_err_in,
   input  logic              refresh_pulse,
   input  logic              t2_out,
   input  logic              nmi_mask,
   input  logic              par_cfg_dis,
   output logic              t2_gate,
   output logic              spkr_out,
   output logic              nmi_req
);
   localparam int unsigned CTRL_W = $bits(ctrl_t);

   logic  hit;
   ctrl_t ctrl_q;
   logic  par_lat, chk_lat, ref_tog;
   logic  par_en, chk_en;
   logic  unused_wr_hi;

   assign unused_wr_hi = ^io_wdata[7:CTRL_W];

   scp_addr_dec #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
      .addr (io_addr),
      .hit  (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           ctrl_q <= '0;
      else if (io_wr && hit) ctrl_q <= ctrl_t'(io_wdata[CTRL_W-1:0]);
   end

   assign par_en = ~ctrl_q.par_dis & ~par_cfg_dis;
   assign chk_en = ~ctrl_q.chk_dis;

   scp_err_latch #(.EDGE_SENSE(EDGE_SENSE)) u_par (
      .clk (clk), .rst_n (rst_n), .err_in (par_err_in), .enable (par_en), .flag (par_lat)
   );
   scp_err_latch #(.EDGE_SENSE(EDGE_SENSE)) u_chk (
      .clk (clk), .rst_n (rst_n), .err_in (chk_err_in), .enable (chk_en), .flag (chk_lat)
   );
   scp_toggle u_ref (
      .clk (clk), .rst_n (rst_n), .pulse (refresh_pulse), .q (ref_tog)
   );

   always_comb begin
      io_rdata = '0;
      if (io_rd && hit) begin
         io_rdata[CTRL_W-1:0] = ctrl_q;
         io_rdata[BIT_REFTOG] = ref_tog;
         io_rdata[BIT_T2OUT]  = t2_out;
         io_rdata[BIT_CHK]    = chk_lat | chk_err_in;
         io_rdata[BIT_PAR]    = par_lat;
      end
   end

   assign t2_gate  = ctrl_q.t2_gate;
   assign spkr_out = t2_out & ctrl_q.spkr_en;
   assign nmi_req  = (par_lat | chk_lat) & ~nmi_mask;
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              t2_out,
   input logic              nmi_mask,
   input logic              refresh_pulse,
   input logic              t2_gate,
   input logic              spkr_out,
   input logic              nmi_req,
   input logic              hit,
   input logic              par_lat,
   input logic              chk_lat,
   input logic              chk_dis,
   input logic              ref_tog
);
   p_even_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_addr[0]) |-> io_rdata == 8'h00);

   p_gate_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit) |=> t2_gate == $past(io_wdata[0]));

   p_spkr_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spkr_out |-> t2_out);

   p_ref_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_pulse |=> ref_tog != $past(ref_tog));

   p_chk_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chk_dis) |-> !chk_lat);

   p_nmi_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_mask |-> !nmi_req);

   p_nmi_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> (par_lat || chk_lat));
endmodule

bind sys_ctl_port scp_chk #(.ADDR_W(ADDR_W)) u_scp_chk (
   .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_rd (io_rd), .io_wr (io_wr),
   .io_wdata (io_wdata), .io_rdata (io_rdata), .t2_out (t2_out), .nmi_mask (nmi_mask),
   .refresh_pulse (refresh_pulse), .t2_gate (t2_gate), .spkr_out (spkr_out),
   .nmi_req (nmi_req), .hit (hit), .par_lat (par_lat), .chk_lat (chk_lat),
   .chk_dis (ctrl_q.chk_dis), .ref_tog (ref_tog)
);

// File: tb/sim_sys_ctl_port.sv
module sim_sys_ctl_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        par_err_in = 1'b0, chk_err_in = 1'b0, refresh_pulse = 1'b0;
   logic        t2_out = 1'b0, nmi_mask = 1'b0, par_cfg_dis = 1'b0;
   logic        t2_gate, spkr_out, nmi_req;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sys_ctl_port u0 (
      .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_rd (io_rd), .io_wr (io_wr),
      .io_wdata (io_wdata), .io_rdata (io_rdata), .par_err_in (par_err_in),
      .chk_err_in (chk_err_in), .refresh_pulse (refresh_pulse), .t2_out (t2_out),
      .nmi_mask (nmi_mask), .par_cfg_dis (par_cfg_dis), .t2_gate (t2_gate),
      .spkr_out (spkr_out), .nmi_req (nmi_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk); io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(16'h61, d);
      check("R2 reset read", d, 8'h00);
      check("R2 reset outs", {5'b0, t2_gate, spkr_out, nmi_req}, 8'h00);
   endtask

   task automatic t_decode();
      logic [7:0] d;
      wr(16'h63, 8'h01);
      check("R3 gate set", {7'b0, t2_gate}, 8'h01);
      wr(16'h62, 8'h00);
      check("R1 even ignored", {7'b0, t2_gate}, 8'h01);
      wr(16'h71, 8'h00);
      check("R1 above window ignored", {7'b0, t2_gate}, 8'h01);
      wr(16'h5F, 8'h00);
      check("R1 below window ignored", {7'b0, t2_gate}, 8'h01);
      wr(16'h6F, 8'h03);
      rd(16'h64, d);
      check("R1 even read zero", d, 8'h00);
      rd(16'h61, d);
      check("R1 low alias read", d, 8'h03);
      io_addr = 16'h65; #1;
      check("R1 no strobe zero", io_rdata, 8'h00);
      wr(16'h6F, 8'h00);
      check("R3 gate clear", {7'b0, t2_gate}, 8'h00);
   endtask

   task automatic t_speaker();
      wr(16'h61, 8'h00);
      t2_out = 1'b1; #1;
      check("R4 speaker forced low", {7'b0, spkr_out}, 8'h00);
      wr(16'h61, 8'h02);
      check("R4 speaker follows hi", {7'b0, spkr_out}, 8'h01);
      t2_out = 1'b0; #1;
      check("R4 speaker follows lo", {7'b0, spkr_out}, 8'h00);
      wr(16'h61, 8'h00);
   endtask

   task automatic t_live_bits();
      logic [7:0] d;
      t2_out = 1'b1;
      rd(16'h67, d);
      check("R5 t2_out hi", {7'b0, d[5]}, 8'h01);
      t2_out = 1'b0;
      rd(16'h67, d);
      check("R5 t2_out lo", {7'b0, d[5]}, 8'h00);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); refresh_pulse = 1'b1;
         @(negedge clk); refresh_pulse = 1'b0;
      end
      rd(16'h69, d);
      check("R6 three toggles", {7'b0, d[4]}, 8'h01);
      @(negedge clk); refresh_pulse = 1'b1;
      @(negedge clk); refresh_pulse = 1'b0;
      rd(16'h69, d);
      check("R6 four toggles", {7'b0, d[4]}, 8'h00);
   endtask

   task automatic t_parity();
      logic [7:0] d;
      @(negedge clk); par_err_in = 1'b1;
      @(negedge clk); par_err_in = 1'b0;
      rd(16'h61, d);
      check("R7 parity flag", {7'b0, d[7]}, 8'h01);
      check("R10 nmi from parity", {7'b0, nmi_req}, 8'h01);
      nmi_mask = 1'b1; #1;
      check("R10 nmi masked", {7'b0, nmi_req}, 8'h00);
      nmi_mask = 1'b0;
      wr(16'h61, 8'h04); cyc(1);
      rd(16'h61, d);
      check("R8 parity cleared", {7'b0, d[7]}, 8'h00);
      check("R8 nmi gone", {7'b0, nmi_req}, 8'h00);
      @(negedge clk); par_err_in = 1'b1;
      @(negedge clk); par_err_in = 1'b0;
      rd(16'h61, d);
      check("R8 blocked by bit2", {7'b0, d[7]}, 8'h00);
      wr(16'h61, 8'h00);
      par_cfg_dis = 1'b1;
      @(negedge clk); par_err_in = 1'b1;
      @(negedge clk); par_err_in = 1'b0;
      rd(16'h61, d);
      check("R8 blocked by cfg", {7'b0, d[7]}, 8'h00);
      par_cfg_dis = 1'b0;
      @(negedge clk); par_err_in = 1'b1; cyc(1);
      wr(16'h61, 8'h04); cyc(1);
      wr(16'h61, 8'h00); cyc(2);
      rd(16'h61, d);
      check("R7 held level no recapture", {7'b0, d[7]}, 8'h00);
      par_err_in = 1'b0; cyc(1);
   endtask

   task automatic t_chk();
      logic [7:0] d;
      @(negedge clk); chk_err_in = 1'b1;
      @(negedge clk); chk_err_in = 1'b0;
      rd(16'h6B, d);
      check("R9 chk flag", {7'b0, d[6]}, 8'h01);
      check("R10 nmi from chk", {7'b0, nmi_req}, 8'h01);
      chk_err_in = 1'b1;
      wr(16'h6B, 8'h08); cyc(1);
      rd(16'h6B, d);
      check("R9 raw seen while disabled", {7'b0, d[6]}, 8'h01);
      check("R9 no nmi while disabled", {7'b0, nmi_req}, 8'h00);
      chk_err_in = 1'b0;
      rd(16'h6B, d);
      check("R9 raw low clears bit6", {7'b0, d[6]}, 8'h00);
      wr(16'h6B, 8'h00);
   endtask

   task automatic t_readonly();
      logic [7:0] d;
      wr(16'h6D, 8'hF0);
      rd(16'h6D, d);
      check("R11 status writes ignored", d, 8'h00);
      wr(16'h6D, 8'hFA);
      rd(16'h6D, d);
      check("R11 full byte read", d, 8'h0A);
      wr(16'h6D, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_decode();
      t_speaker();
      t_live_bits();
      t_parity();
      t_chk();
      t_readonly();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule